// File: doc/BRIEF.md
# Strap-Addressed Write-Only Control Target

This block is a receive-only two-wire serial target that accepts control bytes for an audio power subsystem. It samples the bus clock and data lines on a fast system clock and detects bus conditions from the sampled levels. It answers only to its own address. Every byte that follows the address is handed to a downstream register decoder on a single-cycle strobe.

The target address is seven fixed bits plus a write flag. One of the fixed bits comes from a board strap pin, so two of these targets can share one bus. The block only pulls the data line low, for acknowledges, through an open-drain enable. It never stretches the clock and never returns data. After an address match it accepts any number of bytes until the bus is stopped or restarted. A synchronous reset returns it to idle with the line released.

The system clock must run at least sixteen times the bus clock rate. The bus clock and data lines pass through two-flop synchronizers. Bus conditions and clock edges are found by comparing the synchronized levels from one system cycle to the next.

Top module: `ctl_i2c_target`

## Requirements
- R1: After a synchronous reset, the data-line enable `sda_oe_o` is 0 and `rx_vld_o` is 0.
- R2: The eight bus bits after a START form an address byte, sent MSB first. The target pulls SDA low during the ninth clock only when that byte equals `1111_10S0` in binary, where S is the level of `strap_i`. It stays released for every other byte value.
- R3: After an address mismatch, the bus is ignored until the next START. Later bytes get no acknowledge and produce no `rx_vld_o` pulse.
- R4: Data bits are taken on SCL rising edges, MSB first. The byte on `rx_byte_o` during the strobe equals the byte the controller sent.
- R5: Every data byte received after a matching address is acknowledged on its ninth clock. The enable asserts only while SCL is low.
- R6: Any number of data bytes may follow one address. Each produces its own strobe, in bus order.
- R7: `rx_vld_o` is high for exactly one system clock per data byte. It pulses after the eighth data bit and before the acknowledge clock rises. The enable is low during that cycle.
- R8: A START in the middle of a transfer (SDA falling while SCL is high) discards any partial byte and restarts address reception.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. Clock pulses seen afterwards without a START are ignored.
- R10: A reset asserted while the target is driving an acknowledge releases SDA. Bytes that follow without a new START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level, asynchronous |
| sda_i | input | 1 | Bus data level as seen on the wire, asynchronous |
| strap_i | input | 1 | Address strap, supplies address bit 1 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| rx_byte_o | output | 8 | Last received data byte |
| rx_vld_o | output | 1 | One-cycle strobe marking a new data byte |

## Verification
The bench sweeps all 256 address byte values under both strap levels. A compare that ignores the strap bit, or that accepts a read flag, would then acknowledge a foreign byte. Multi-byte runs with bit patterns weighted to the MSB and to the LSB expose bit-order or off-by-one counting errors. The same runs catch strobes that last two cycles or that land after the acknowledge clock. A repeated START after three bits would leave a misaligned byte if the bit counter were not cleared. Bare clock pulses after a STOP, after a mismatch, and after a reset taken during an acknowledge would show up as phantom strobes or acknowledges if the idle state were not honoured.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK_WAIT,
        ST_ACK_HIGH,
        ST_ACK_DONE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shf;
        logic               oe;
        logic               vld;
        logic [BYTE_W-1:0]  dat;
    } tgt_regs_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_prev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    line_prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    // Conditions only count while the clock is high on both samples.
    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign start_evt = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_evt  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [BYTE_W-3:0] ADDR_HI = 6'b111110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              strap_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              oe,
    output logic [BYTE_W-1:0] dat,
    output logic              vld
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    tgt_regs_t          r_d, r_q;
    logic [BYTE_W-1:0]  full_byte;
    logic [BYTE_W-1:0]  own_addr;
    logic               last_bit;

    assign own_addr  = {ADDR_HI, strap_s, 1'b0};
    assign full_byte = {r_q.shf[BYTE_W-2:0], sda_s};
    assign last_bit  = (r_q.cnt == LAST_BIT);

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (stop_evt) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_evt) begin
            r_d.st  = ST_ADDR;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shf = full_byte;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (last_bit) begin
                            r_d.cnt = '0;
                            r_d.st  = (full_byte == own_addr) ? ST_ACK_WAIT : ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        r_d.shf = full_byte;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (last_bit) begin
                            r_d.cnt = '0;
                            r_d.vld = 1'b1;
                            r_d.dat = full_byte;
                            r_d.st  = ST_ACK_WAIT;
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b1;
                        r_d.st = ST_ACK_HIGH;
                    end
                end
                ST_ACK_HIGH: begin
                    if (scl_rise) begin
                        r_d.st = ST_ACK_DONE;
                    end
                end
                ST_ACK_DONE: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_DATA;
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, cnt: '0, shf: '0, oe: 1'b0, vld: 1'b0, dat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign oe  = r_q.oe;
    assign dat = r_q.dat;
    assign vld = r_q.vld;
endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-3:0] ADDR_HI     = 6'b111110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_vld_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw_in, sync_out;
    logic            scl_s, sda_s, strap_s;
    logic            scl_rise, scl_fall, start_evt, stop_evt;

    assign raw_in = {strap_i, sda_i, scl_i};

    i2c_tgt_sync #(
        .W       (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b0, 1'b1, 1'b1})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign scl_s   = sync_out[0];
    assign sda_s   = sync_out[1];
    assign strap_s = sync_out[2];

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_fsm #(
        .ADDR_HI (ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sda_s     (sda_s),
        .strap_s   (strap_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .oe        (sda_oe_o),
        .dat       (rx_byte_o),
        .vld       (rx_vld_o)
    );
endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic vld,
    input logic scl_s,
    input logic stop_evt
);
    logic rst_d1;

    always_ff @(posedge clk) begin
        rst_d1 <= rst;
    end

    // R1
    always @(negedge clk) begin
        if (rst_d1 === 1'b1) begin
            released_after_reset_chk: assert (!sda_oe && !vld);
        end
    end

    // R7
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R7
    strobe_outside_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> !sda_oe);

    // R5
    ack_on_low_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R9
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);
endmodule

bind ctl_i2c_target ctl_i2c_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe_o),
    .vld      (rx_vld_o),
    .scl_s    (scl_s),
    .stop_evt (stop_evt)
);

// File: tb/ctl_i2c_target_test.sv
module ctl_i2c_target_test;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_oe;
    logic [7:0] rx_byte;
    logic       rx_vld;
    wire        sda_line = sda_m & ~sda_oe;

    int nchk = 0;
    int nfail = 0;
    int nvld = 0;
    int wide = 0;
    logic prev_vld = 1'b0;
    logic [7:0] got [0:15];

    always #2 clk = ~clk;

    ctl_i2c_target uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_oe_o  (sda_oe),
        .rx_byte_o (rx_byte),
        .rx_vld_o  (rx_vld)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_vld) begin
                got[nvld % 16] = rx_byte;
                nvld++;
                if (prev_vld) wide++;
            end
            prev_vld = rx_vld;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output int strobes);
        int s0;
        s0 = nvld;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        strobes = nvld - s0;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = !sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        bit ack;
        int sb;
        int base;
        logic [7:0] bytes [0:5];
        bytes[0] = 8'h80; bytes[1] = 8'h01; bytes[2] = 8'h5A;
        bytes[3] = 8'hFF; bytes[4] = 8'h00; bytes[5] = 8'hC3;

        // R1: reset state
        wq(4);
        rst = 1'b0;
        wq(1);
        chk(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
        chk(rx_vld == 1'b0, "R1 vld", rx_vld, 0);

        // R2: every address byte under both strap levels
        base = nvld;
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            wq(Q);
            for (int a = 0; a < 256; a++) begin
                bit exp_ack;
                exp_ack = (a[7:0] == {6'b111110, s[0], 1'b0});
                bus_start();
                send_byte(a[7:0], ack, sb);
                chk(ack == exp_ack, "R2 address ack", int'(ack), int'(exp_ack));
                bus_stop();
            end
        end
        chk(nvld == base, "R2 no strobe from address", nvld - base, 0);

        // R4 R5 R6 R7: several bytes after one address
        strap = 1'b1; wq(Q);
        base = nvld;
        bus_start();
        send_byte(8'hFA, ack, sb);
        chk(ack, "R2 strap high match", int'(ack), 1);
        for (int i = 0; i < 6; i++) begin
            send_byte(bytes[i], ack, sb);
            chk(ack, "R5 data ack", int'(ack), 1);
            chk(sb == 1, "R7 strobe before ack clock", sb, 1);
            chk(got[(nvld - 1) % 16] == bytes[i], "R4 byte value",
                int'(got[(nvld - 1) % 16]), int'(bytes[i]));
        end
        bus_stop();
        chk(nvld - base == 6, "R6 strobe count", nvld - base, 6);
        chk(wide == 0, "R7 strobe width", wide, 0);

        // R3: mismatch ignores following bytes
        base = nvld;
        bus_start();
        send_byte(8'hF8, ack, sb);
        chk(!ack, "R3 mismatch nack", int'(ack), 0);
        send_byte(8'h3C, ack, sb);
        chk(!ack, "R3 data after mismatch nack", int'(ack), 0);
        bus_stop();
        chk(nvld == base, "R3 no strobe", nvld - base, 0);

        // R8: repeated start discards partial byte
        base = nvld;
        bus_start();
        send_byte(8'hFA, ack, sb);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'hFA, ack, sb);
        chk(ack, "R8 readdress ack", int'(ack), 1);
        send_byte(8'h96, ack, sb);
        chk(nvld - base == 1, "R8 one strobe", nvld - base, 1);
        chk(got[(nvld - 1) % 16] == 8'h96, "R8 aligned byte",
            int'(got[(nvld - 1) % 16]), 8'h96);
        bus_start();
        send_byte(8'hFE, ack, sb);
        chk(!ack, "R8 restart to foreign address", int'(ack), 0);
        send_byte(8'h11, ack, sb);
        bus_stop();
        chk(nvld - base == 1, "R8 foreign data ignored", nvld - base, 1);

        // R9: clocks after stop are ignored
        bus_start();
        send_byte(8'hFA, ack, sb);
        send_byte(8'h42, ack, sb);
        bus_stop();
        base = nvld;
        scl_m = 1'b0; wq(Q);
        send_byte(8'h77, ack, sb);
        chk(!ack, "R9 no ack after stop", int'(ack), 0);
        chk(nvld == base, "R9 no strobe after stop", nvld - base, 0);
        bus_stop();

        // R10: reset during an acknowledge
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(8'hFA >> i);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(1);
        chk(sda_oe == 1'b1, "R10 ack driven before reset", sda_oe, 1);
        rst = 1'b1; wq(2);
        chk(sda_oe == 1'b0, "R10 released by reset", sda_oe, 0);
        rst = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
        base = nvld;
        send_byte(8'h55, ack, sb);
        chk(!ack, "R10 no ack after reset", int'(ack), 0);
        chk(nvld == base, "R10 no strobe after reset", nvld - base, 0);
        bus_stop();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule